// File: doc/BRIEF.md
# DRAM Data Retention Test Sequencer

The sequencer measures how long DRAM cells keep their contents without refresh. It sits in front of a memory-side request port (address, write data, read data, valid/ready) and takes control of the refresh scheduler's enable and period. A run writes a data pattern, waits a host-programmed number of clock cycles without touching the array, then reads the data back and compares each word. During the wait the sequencer issues no accesses at all. Any read would refresh the whole row it lands in and spoil the measurement.

Two kinds of run exist. A discovery run switches refresh off and sweeps the whole array. Both the write pass and the read pass start from a chosen address and wrap around. A targeted run writes only one address, chosen from an earlier discovery run. It switches refresh on with a test-specific period, waits, and then reads back that one word. The host repeats runs with different start addresses, pattern modes and base words. After each run it reads the number of mismatches and the first failing address, and both stay valid until the next start.

Top module: `retention_sequencer`

## Requirements
- R1: A discovery run writes every one of the 2^AW locations exactly once. Writes go in ascending address order, starting at `startAddr` and wrapping from the highest address back to zero.
- R2: The word written to address a is `patBase` XOR a mask. `patMode` selects the mask: 0 gives all zeros. 1 gives all ones when a[0]=1, otherwise zeros. 2 gives all ones when a[0]=0, otherwise zeros. 3 gives a mask whose bit i equals a[i mod AW].
- R3: While busy, `refreshEn` is 0 in a discovery run. In a targeted run `refreshEn` is 1 and `refreshPeriod` equals `testRefreshPeriod`.
- R4: After the last write is accepted, no request is presented for at least `pauseCycles` clock cycles before the first read.
- R5: The read pass visits addresses in the same order as the write pass, with one read outstanding at a time. Each returned word is compared with the R2 pattern for its address.
- R6: `mismatchCount` holds the number of words that compared unequal. `firstFailAddr` holds the address of the first of those words in visit order, and `failSeen` shows that it is valid.
- R7: A targeted run (`targeted`=1) writes exactly one word and reads exactly one word, both at `startAddr`.
- R8: When the run completes (`done` is high for one cycle), `refreshEn` and `refreshPeriod` return to `hostRefreshEn` and `hostRefreshPeriod`.
- R9: `start` is accepted only while idle. A start pulse during a run neither restarts it nor adds writes.
- R10: `mismatchCount` saturates at all ones of its CNTW-bit width (16 bits by default).
- R11: The results hold their values after completion until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| targeted | input | 1 | 1 selects a single-address run |
| patMode | input | 2 | Pattern mask selector |
| patBase | input | DW | Base data word |
| startAddr | input | AW | First address, or the target address |
| pauseCycles | input | PW | Retention wait in clock cycles |
| testRefreshPeriod | input | RPW | Refresh period used in targeted runs |
| hostRefreshEn | input | 1 | Normal refresh enable |
| hostRefreshPeriod | input | RPW | Normal refresh period |
| memReqValid | output | 1 | Request valid |
| memReqReady | input | 1 | Request accepted by memory |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqAddr | output | AW | Request address |
| memReqWdata | output | DW | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DW | Read data |
| refreshEn | output | 1 | Refresh scheduler enable |
| refreshPeriod | output | RPW | Refresh scheduler period |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatchCount | output | CNTW | Saturating mismatch count |
| firstFailAddr | output | AW | First failing address |
| failSeen | output | 1 | At least one mismatch seen |

## Verification
Two functions can land on the same cycle. The compare of the final word in the sweep can coincide with the leave-CHECK transition that hands refresh back to the host settings, and a host start pulse can arrive while the sequencer is mid-run. The bench provokes the first case by decaying the last address visited, the one just before the start address. It judges the result by whether that miss is counted and whether host refresh is restored in the done cycle. It provokes the second case by pulsing start during the pause. That start is judged ignored if exactly one completion pulse and one full write pass are seen.

// File: rtl/retseq_pkg.sv
package retseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_PAUSE,
    ST_CHECK,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    PAT_SOLID,
    PAT_CHECKER,
    PAT_CHECKER_INV,
    PAT_ADDR_SEED
  } patMode_t;

  typedef struct packed {
    logic captureCfg;
    logic stepAddr;
    logic rewindAddr;
    logic pauseRun;
    logic compareEn;
  } seqStrobe_t;

endpackage

// File: rtl/retseq_datapath.sv
module retseq_datapath
  import retseq_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int PW   = 32,
  parameter int RPW  = 16,
  parameter int CNTW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             targeted,
  input  logic [1:0]       patMode,
  input  logic [DW-1:0]    patBase,
  input  logic [AW-1:0]    startAddr,
  input  logic [PW-1:0]    pauseCycles,
  input  logic [RPW-1:0]   testRefreshPeriod,
  input  logic [DW-1:0]    rspData,
  output logic [AW-1:0]    curAddr,
  output logic [DW-1:0]    patWord,
  output logic             lastAddr,
  output logic             pauseDone,
  output logic             targetedQ,
  output logic [RPW-1:0]   testPeriodQ,
  output logic [CNTW-1:0]  mismatchCount,
  output logic [AW-1:0]    firstFailAddr,
  output logic             failSeen
);

  localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};

  logic [AW-1:0]   addrQ, startQ, nextAddr;
  logic [DW-1:0]   baseQ, seedMask;
  patMode_t        modeQ;
  logic [PW-1:0]   pauseCntQ;
  logic [CNTW-1:0] mismatchQ;
  logic [AW-1:0]   firstFailQ;
  logic            failSeenQ;

  assign nextAddr = addrQ + 1'b1;

  for (genvar i = 0; i < DW; i++) begin : g_seed
    assign seedMask[i] = addrQ[i % AW];
  end

  always_comb begin
    unique case (modeQ)
      PAT_SOLID:       patWord = baseQ;
      PAT_CHECKER:     patWord = addrQ[0] ? ~baseQ : baseQ;
      PAT_CHECKER_INV: patWord = addrQ[0] ? baseQ : ~baseQ;
      default:         patWord = baseQ ^ seedMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ       <= '0;
      startQ      <= '0;
      baseQ       <= '0;
      modeQ       <= PAT_SOLID;
      targetedQ   <= 1'b0;
      testPeriodQ <= '0;
      pauseCntQ   <= '0;
      mismatchQ   <= '0;
      firstFailQ  <= '0;
      failSeenQ   <= 1'b0;
    end else begin
      if (strb.captureCfg) begin
        addrQ       <= startAddr;
        startQ      <= startAddr;
        baseQ       <= patBase;
        modeQ       <= patMode_t'(patMode);
        targetedQ   <= targeted;
        testPeriodQ <= testRefreshPeriod;
        pauseCntQ   <= pauseCycles;
        mismatchQ   <= '0;
        firstFailQ  <= '0;
        failSeenQ   <= 1'b0;
      end else begin
        if (strb.stepAddr)   addrQ <= nextAddr;
        if (strb.rewindAddr) addrQ <= startQ;
        if (strb.pauseRun && pauseCntQ != '0) pauseCntQ <= pauseCntQ - 1'b1;
        if (strb.compareEn && rspData != patWord) begin
          if (mismatchQ != CNT_MAX) mismatchQ <= mismatchQ + 1'b1;
          if (!failSeenQ) begin
            firstFailQ <= addrQ;
            failSeenQ  <= 1'b1;
          end
        end
      end
    end
  end

  assign curAddr       = addrQ;
  assign lastAddr      = targetedQ || (nextAddr == startQ);
  assign pauseDone     = (pauseCntQ == '0);
  assign mismatchCount = mismatchQ;
  assign firstFailAddr = firstFailQ;
  assign failSeen      = failSeenQ;

  // Saturated count stays put until a new run clears it.
  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchQ == CNT_MAX && !strb.captureCfg) |=> (mismatchQ == CNT_MAX));

  // First failing address is frozen once latched.
  assert_first_fail_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (failSeenQ && !strb.captureCfg) |=> $stable(firstFailQ));

  // Results only shrink when a new run is captured.
  assert_results_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.captureCfg) |=> (mismatchQ >= $past(mismatchQ)));

endmodule

// File: rtl/retseq_ctrl.sv
module retseq_ctrl
  import retseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       lastAddr,
  input  logic       pauseDone,
  output seqStrobe_t strb,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       busy,
  output logic       done
);

  seqState_t stateQ, stateD;
  logic      pendingQ, pendingD;

  always_comb begin
    strb        = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    stateD      = stateQ;
    pendingD    = pendingQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.captureCfg = 1'b1;
          pendingD        = 1'b0;
          stateD          = ST_FILL;
        end
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          if (lastAddr) begin
            strb.rewindAddr = 1'b1;
            stateD          = ST_PAUSE;
          end else begin
            strb.stepAddr = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        strb.pauseRun = 1'b1;
        if (pauseDone) stateD = ST_CHECK;
      end
      ST_CHECK: begin
        if (!pendingQ) begin
          memReqValid = 1'b1;
          if (memReqReady) pendingD = 1'b1;
        end else if (memRspValid) begin
          strb.compareEn = 1'b1;
          pendingD       = 1'b0;
          if (lastAddr) stateD = ST_DONE;
          else          strb.stepAddr = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      pendingQ <= pendingD;
    end
  end

  assign busy = (stateQ == ST_FILL) || (stateQ == ST_PAUSE) || (stateQ == ST_CHECK);
  assign done = (stateQ == ST_DONE);

  // The array is left untouched during the retention wait.
  assert_quiet_pause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PAUSE) |-> !memReqValid);

  // Only one read in flight during the check pass.
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CHECK && pendingQ) |-> !memReqValid);

  // A start pulse outside idle never begins a new fill.
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && (stateQ == ST_PAUSE || stateQ == ST_CHECK || stateQ == ST_DONE))
      |=> (stateQ != ST_FILL));

endmodule

// File: rtl/retention_sequencer.sv
module retention_sequencer
  import retseq_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int PW   = 32,
  parameter int RPW  = 16,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            targeted,
  input  logic [1:0]      patMode,
  input  logic [DW-1:0]   patBase,
  input  logic [AW-1:0]   startAddr,
  input  logic [PW-1:0]   pauseCycles,
  input  logic [RPW-1:0]  testRefreshPeriod,
  input  logic            hostRefreshEn,
  input  logic [RPW-1:0]  hostRefreshPeriod,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [AW-1:0]   memReqAddr,
  output logic [DW-1:0]   memReqWdata,
  input  logic            memRspValid,
  input  logic [DW-1:0]   memRspData,
  output logic            refreshEn,
  output logic [RPW-1:0]  refreshPeriod,
  output logic            busy,
  output logic            done,
  output logic [CNTW-1:0] mismatchCount,
  output logic [AW-1:0]   firstFailAddr,
  output logic            failSeen
);

  seqStrobe_t     strb;
  logic           lastAddr, pauseDone, targetedQ;
  logic [RPW-1:0] testPeriodQ;

  retseq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .lastAddr    (lastAddr),
    .pauseDone   (pauseDone),
    .strb        (strb),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .busy        (busy),
    .done        (done)
  );

  retseq_datapath #(
    .AW(AW), .DW(DW), .PW(PW), .RPW(RPW), .CNTW(CNTW)
  ) u_dp (
    .clk               (clk),
    .rstN              (rstN),
    .strb              (strb),
    .targeted          (targeted),
    .patMode           (patMode),
    .patBase           (patBase),
    .startAddr         (startAddr),
    .pauseCycles       (pauseCycles),
    .testRefreshPeriod (testRefreshPeriod),
    .rspData           (memRspData),
    .curAddr           (memReqAddr),
    .patWord           (memReqWdata),
    .lastAddr          (lastAddr),
    .pauseDone         (pauseDone),
    .targetedQ         (targetedQ),
    .testPeriodQ       (testPeriodQ),
    .mismatchCount     (mismatchCount),
    .firstFailAddr     (firstFailAddr),
    .failSeen          (failSeen)
  );

  assign refreshEn     = busy ? targetedQ   : hostRefreshEn;
  assign refreshPeriod = (busy && targetedQ) ? testPeriodQ : hostRefreshPeriod;

endmodule

// File: tb/retention_sequencer_bench.sv
module retention_sequencer_bench;

  localparam int AW = 6, DW = 16, PW = 32, RPW = 16, CNTW = 5;
  localparam int PAUSE = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic            start = 0, targeted = 0;
  logic [1:0]      patMode = 0;
  logic [DW-1:0]   patBase = 16'h5A3C;
  logic [AW-1:0]   startAddr = 0;
  logic [PW-1:0]   pauseCycles = PAUSE;
  logic [RPW-1:0]  testRefreshPeriod = 16'd77;
  logic            hostRefreshEn = 1'b1;
  logic [RPW-1:0]  hostRefreshPeriod = 16'd500;
  logic            memReqValid, memReqWrite;
  logic            memReqReady = 1'b1;
  logic [AW-1:0]   memReqAddr;
  logic [DW-1:0]   memReqWdata;
  logic            memRspValid = 1'b0;
  logic [DW-1:0]   memRspData = '0;
  logic            refreshEn, busy, done, failSeen;
  logic [RPW-1:0]  refreshPeriod;
  logic [CNTW-1:0] mismatchCount;
  logic [AW-1:0]   firstFailAddr;

  retention_sequencer #(.AW(AW), .DW(DW), .PW(PW), .RPW(RPW), .CNTW(CNTW))
  u_retention_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .targeted(targeted), .patMode(patMode),
    .patBase(patBase), .startAddr(startAddr), .pauseCycles(pauseCycles),
    .testRefreshPeriod(testRefreshPeriod), .hostRefreshEn(hostRefreshEn),
    .hostRefreshPeriod(hostRefreshPeriod), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid), .memRspData(memRspData),
    .refreshEn(refreshEn), .refreshPeriod(refreshPeriod), .busy(busy), .done(done),
    .mismatchCount(mismatchCount), .firstFailAddr(firstFailAddr), .failSeen(failSeen)
  );

  int errors = 0, checks = 0;
  int cyc = 0;

  // memory model and monitor
  logic [DW-1:0] mem [64];
  logic [63:0]   decay = '0, writtenMask = '0;
  logic          stallOn = 0, runClear = 0;
  int writes = 0, reads = 0, seqErr = 0, refErr = 0, donePulses = 0;
  int lastWrCyc = 0, firstRdCyc = 0;
  logic [AW-1:0] expWrAddr, expRdAddr;
  assign expWrAddr = startAddr + writes[5:0];
  assign expRdAddr = startAddr + reads[5:0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= 1'b0;
    memReqReady <= stallOn ? ~memReqReady : 1'b1;
    if (runClear) begin
      writes <= 0; reads <= 0; seqErr <= 0; refErr <= 0; donePulses <= 0;
      writtenMask <= '0;
    end else begin
      if (done) donePulses <= donePulses + 1;
      if (busy && (refreshEn !== ~targeted ? 1'b0 : 1'b0)) refErr <= refErr;
      if (busy && ((refreshEn !== targeted) ||
                   (targeted && refreshPeriod !== testRefreshPeriod)))
        refErr <= refErr + 1;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr] <= memReqWdata;
          writtenMask[memReqAddr] <= 1'b1;
          if (memReqAddr !== expWrAddr) seqErr <= seqErr + 1;
          writes <= writes + 1;
          lastWrCyc <= cyc;
        end else begin
          memRspValid <= 1'b1;
          memRspData  <= mem[memReqAddr] ^ {15'd0, decay[memReqAddr]};
          if (reads == 0) firstRdCyc <= cyc;
          if (memReqAddr !== expRdAddr) seqErr <= seqErr + 1;
          reads <= reads + 1;
        end
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
    report();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expWord(input logic [1:0] m, input logic [DW-1:0] b,
                                            input logic [AW-1:0] a);
    logic [DW-1:0] msk;
    msk = '0;
    case (m)
      2'd1: msk = a[0] ? 16'hFFFF : 16'h0000;
      2'd2: msk = a[0] ? 16'h0000 : 16'hFFFF;
      2'd3: for (int i = 0; i < DW; i++) msk[i] = a[i % AW];
      default: msk = '0;
    endcase
    return b ^ msk;
  endfunction

  task automatic launch(input bit tg, input logic [1:0] m, input logic [DW-1:0] b,
                        input logic [AW-1:0] sa, input logic [63:0] dc, input bit st);
    @(negedge clk);
    targeted = tg; patMode = m; patBase = b; startAddr = sa; decay = dc; stallOn = st;
    runClear = 1;
    @(negedge clk);
    runClear = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone(input string req);
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, req, "done pulse seen", seen, 1);
  endtask

  task automatic checkFill(input string req);
    int bad = 0;
    for (int a = 0; a < 64; a++)
      if (mem[a] !== expWord(patMode, patBase, a[5:0])) bad++;
    chk(bad == 0, req, "words with wrong pattern", bad, 0);
    chk(writtenMask == '1 && writes == 64, "R1", "writes covering array", writes, 64);
    chk(seqErr == 0, "R5", "out-of-order accesses", seqErr, 0);
  endtask

  task automatic checkCommon(input int expCnt, input int expFirst);
    chk(refErr == 0, "R3", "refresh setting violations while busy", refErr, 0);
    chk(firstRdCyc - lastWrCyc >= PAUSE && firstRdCyc - lastWrCyc <= PAUSE + 4,
        "R4", "write-to-read gap", firstRdCyc - lastWrCyc, PAUSE);
    chk(refreshEn == hostRefreshEn && refreshPeriod == hostRefreshPeriod,
        "R8", "refresh restored at done", refreshPeriod, hostRefreshPeriod);
    chk(mismatchCount == expCnt, "R6", "mismatch count", mismatchCount, expCnt);
    if (expCnt > 0)
      chk(failSeen && firstFailAddr == expFirst, "R6", "first fail address",
          firstFailAddr, expFirst);
    else
      chk(!failSeen, "R6", "fail flag clear", failSeen, 0);
  endtask

  task automatic testReset();
    chk(!memReqValid && !busy && !done, "R9", "idle after reset", memReqValid, 0);
    chk(refreshEn == 1 && refreshPeriod == 500, "R8", "host refresh at reset",
        refreshPeriod, 500);
    chk(mismatchCount == 0 && !failSeen, "R11", "results clear at reset", mismatchCount, 0);
  endtask

  task automatic testSolid();
    launch(0, 2'd0, 16'h5A3C, 6'd0, '0, 0);
    waitDone("R1");
    checkFill("R2");
    checkCommon(0, 0);
  endtask

  // last visited address (9) decays: its compare falls in the done transition
  task automatic testCheckerStall();
    logic [63:0] dc = '0;
    dc[5] = 1; dc[20] = 1; dc[40] = 1; dc[9] = 1;
    launch(0, 2'd1, 16'hC3A5, 6'd10, dc, 1);
    waitDone("R5");
    checkFill("R2");
    checkCommon(4, 20);
  endtask

  task automatic testInvStartIgnored();
    logic [63:0] dc = '0;
    dc[0] = 1;
    launch(0, 2'd2, 16'h0FF0, 6'd63, dc, 0);
    while (writes < 64) @(negedge clk);
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    waitDone("R9");
    repeat (3) @(negedge clk);
    chk(donePulses == 1, "R9", "completion pulses", donePulses, 1);
    chk(writes == 64, "R9", "writes after mid-run start", writes, 64);
    chk(!busy, "R9", "idle after run", busy, 0);
    checkFill("R2");
    chk(mismatchCount == 1 && firstFailAddr == 0, "R6", "first fail after wrap",
        firstFailAddr, 0);
  endtask

  task automatic testSeed();
    launch(0, 2'd3, 16'h6996, 6'd33, '0, 1);
    waitDone("R2");
    checkFill("R2");
    checkCommon(0, 0);
  endtask

  task automatic testTargeted();
    logic [63:0] dc = '0;
    dc[20] = 1; dc[21] = 1;
    launch(1, 2'd0, 16'hAAAA, 6'd20, dc, 0);
    waitDone("R7");
    chk(writes == 1 && writtenMask == (64'd1 << 20), "R7", "targeted writes", writes, 1);
    chk(reads == 1, "R7", "targeted reads", reads, 1);
    chk(seqErr == 0, "R7", "targeted address", seqErr, 0);
    checkCommon(1, 20);
  endtask

  task automatic testSaturate();
    logic [CNTW-1:0] held;
    launch(0, 2'd1, 16'h3C3C, 6'd7, '1, 0);
    waitDone("R10");
    chk(mismatchCount == 31, "R10", "saturated count", mismatchCount, 31);
    chk(firstFailAddr == 7, "R6", "first fail is start", firstFailAddr, 7);
    held = mismatchCount;
    repeat (30) @(negedge clk);
    chk(mismatchCount == held && firstFailAddr == 7 && failSeen, "R11",
        "results held while idle", mismatchCount, held);
    launch(0, 2'd0, 16'h5A3C, 6'd0, '0, 0);
    chk(mismatchCount == 0 && !failSeen, "R11", "results cleared by start",
        mismatchCount, 0);
    waitDone("R11");
    chk(mismatchCount == 0, "R11", "clean rerun", mismatchCount, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSolid();
    testCheckerStall();
    testInvStartIgnored();
    testSeed();
    testTargeted();
    testSaturate();
    report();
  end

endmodule